// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch Table

This block is the control heart of a microcoded processor. It keeps a microprogram counter that addresses an internal microcode store, and every cycle it presents the control word of the current microinstruction to the datapath. Each microinstruction names a condition and two successor targets. When the condition is true the first target is taken, otherwise the second. A target is an absolute microcode address, the sequential address (counter plus one), or the result of the opcode dispatch table.

The dispatch table turns a 9-bit index into the address of a routine. The index is a page bit followed by the 8-bit opcode. Entries carry a care mask, so one entry can cover a whole opcode group. When several entries match, the one with the most cared-for bits wins, so a single-opcode entry overrides the group entry that also covers it. The fetch microinstruction is the only one that dispatches. The usual routine exit tests the continue flag: when it is set, control returns to fetch; when it is clear, control goes to the DMA/interrupt service word. The idle routine branches to itself until a DMA or interrupt request is pending.

Microprogram (address, control word, successor rule): 0 FETCH 16'h8101 → dispatch; 1 SERVICE 16'h4202 → 0; 2 LOADN 16'h2314, 3 IDLE 16'h0008, 4 INCR 16'h0420, 5 DECR 16'h0440, 6 SHORTBR 16'h2580, 7 SKIP 16'h0520, 8 TAKEBR 16'h0610, 9 LOADADV 16'h2314, 10 STORE 16'h1704, 11 OUTPUT 16'h3820, 12 INDEXINC 16'h0820, 13 INPUT 16'h2914, 14 to 31 TRAP 16'h0000 → 0.

Top module: `useq_core`

## Requirements
- R1: While rst_n is low, and for the first two rising clock edges after it goes high, upc_addr is 0 and ctrl_word is 16'h8101.
- R2: ctrl_word always equals the control word listed above for the address on upc_addr, in the same cycle.
- R3: When upc_addr is 0, the next upc_addr is the dispatch result for the index {op_page, opcode} sampled in that cycle.
- R4: With op_page 0, opcodes 8'h01–8'h0F dispatch to 2, 8'h1x to 4, 8'h2x to 5, 8'h3x to 6, 8'h4x to 9, 8'h5x to 10, 8'h61–8'h67 to 11, and 8'h68–8'h6F to 13.
- R5: With op_page 0, opcode 8'h00 dispatches to 3 and opcode 8'h60 dispatches to 12, overriding their group entries.
- R6: Any index with op_page 1, or with an opcode high nibble of 7 to F, dispatches to the trap address 14.
- R7: At addresses 2, 4, 5, 7, 8, 10, 11, 12 and 13 the next address is 0 when cond_cont is 1 and 1 when cond_cont is 0.
- R8: At address 3 the next address is 3 while cond_pend is 0, and 1 when cond_pend is 1.
- R9: At address 6 the next address is 8 when cond_branch is 1 and 7 (the sequential address) when it is 0.
- R10: Addresses 1 and 14 to 31 always go to 0, and address 9 always goes to 4, whatever the condition inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_page | input | 1 | Leading bit of the dispatch index |
| opcode | input | 8 | Fetched opcode, used in the fetch cycle |
| cond_cont | input | 1 | Continue flag tested by routine exits |
| cond_branch | input | 1 | Branch condition for the short-branch routine |
| cond_pend | input | 1 | DMA or interrupt request pending |
| upc_addr | output | 5 | Current microprogram address |
| ctrl_word | output | 16 | Control word of the current microinstruction |

## Verification
The override entries and the idle self-loop are the hard cases. An override can only be seen when exactly opcode 00 or 60 is on the port in the single cycle where the counter sits at fetch. The idle loop only shows its hold when the pending flag stays low over many consecutive cycles. The bench runs a reference model of the counter, so it knows which cycles are dispatch cycles. In those cycles it first applies a directed list of boundary opcodes: the two overrides, the group edges 67/68/6F, unmapped codes and page-1 codes. During the first visit to idle it holds the pending flag low for twenty cycles. After that, the opcodes and flags are random.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int AW     = 5;
  localparam int CW     = 16;
  localparam int OPW    = 8;
  localparam int IDXW   = OPW + 1;
  localparam int N_MAP  = 10;
  localparam int DEPTH  = 1 << AW;

  typedef enum logic [1:0] {
    TK_ABS  = 2'd0,
    TK_NEXT = 2'd1,
    TK_MAP  = 2'd2
  } tgt_kind_e;

  typedef enum logic [1:0] {
    CS_ALWAYS = 2'd0,
    CS_CONT   = 2'd1,
    CS_BRANCH = 2'd2,
    CS_PEND   = 2'd3
  } cond_sel_e;

  typedef struct packed {
    tgt_kind_e       kind;
    logic [AW-1:0]   addr;
  } target_t;

  typedef struct packed {
    logic [CW-1:0]   ctrl;
    cond_sel_e       cond;
    target_t         tgt_a;
    target_t         tgt_b;
  } uword_t;

  typedef struct packed {
    logic [IDXW-1:0] val;
    logic [IDXW-1:0] care;
    logic [AW-1:0]   dest;
  } map_ent_t;

  localparam logic [AW-1:0] A_FETCH   = AW'(0);
  localparam logic [AW-1:0] A_SERVICE = AW'(1);
  localparam logic [AW-1:0] A_LOADN   = AW'(2);
  localparam logic [AW-1:0] A_IDLE    = AW'(3);
  localparam logic [AW-1:0] A_INCR    = AW'(4);
  localparam logic [AW-1:0] A_DECR    = AW'(5);
  localparam logic [AW-1:0] A_SHORTBR = AW'(6);
  localparam logic [AW-1:0] A_SKIP    = AW'(7);
  localparam logic [AW-1:0] A_TAKEBR  = AW'(8);
  localparam logic [AW-1:0] A_LOADADV = AW'(9);
  localparam logic [AW-1:0] A_STORE   = AW'(10);
  localparam logic [AW-1:0] A_OUTPUT  = AW'(11);
  localparam logic [AW-1:0] A_IDXINC  = AW'(12);
  localparam logic [AW-1:0] A_INPUT   = AW'(13);
  localparam logic [AW-1:0] A_TRAP    = AW'(14);

  function automatic target_t mk_tgt(input tgt_kind_e k, input logic [AW-1:0] a);
    target_t t;
    t.kind = k;
    t.addr = a;
    return t;
  endfunction

  function automatic uword_t mk_word(input logic [CW-1:0] c, input cond_sel_e s,
                                     input target_t ta, input target_t tb);
    uword_t w;
    w.ctrl  = c;
    w.cond  = s;
    w.tgt_a = ta;
    w.tgt_b = tb;
    return w;
  endfunction

  // standard routine exit: resume fetching, or divert to request service
  function automatic uword_t exit_word(input logic [CW-1:0] c);
    return mk_word(c, CS_CONT, mk_tgt(TK_ABS, A_FETCH), mk_tgt(TK_ABS, A_SERVICE));
  endfunction

  function automatic uword_t ucode_rom(input logic [AW-1:0] a);
    uword_t w;
    w = mk_word(16'h0000, CS_ALWAYS, mk_tgt(TK_ABS, A_FETCH), mk_tgt(TK_ABS, A_FETCH));
    case (a)
      A_FETCH:   w = mk_word(16'h8101, CS_ALWAYS, mk_tgt(TK_MAP, A_FETCH),
                             mk_tgt(TK_MAP, A_FETCH));
      A_SERVICE: w = mk_word(16'h4202, CS_ALWAYS, mk_tgt(TK_ABS, A_FETCH),
                             mk_tgt(TK_ABS, A_FETCH));
      A_LOADN:   w = exit_word(16'h2314);
      A_IDLE:    w = mk_word(16'h0008, CS_PEND, mk_tgt(TK_ABS, A_SERVICE),
                             mk_tgt(TK_ABS, A_IDLE));
      A_INCR:    w = exit_word(16'h0420);
      A_DECR:    w = exit_word(16'h0440);
      A_SHORTBR: w = mk_word(16'h2580, CS_BRANCH, mk_tgt(TK_ABS, A_TAKEBR),
                             mk_tgt(TK_NEXT, A_FETCH));
      A_SKIP:    w = exit_word(16'h0520);
      A_TAKEBR:  w = exit_word(16'h0610);
      A_LOADADV: w = mk_word(16'h2314, CS_ALWAYS, mk_tgt(TK_ABS, A_INCR),
                             mk_tgt(TK_ABS, A_INCR));
      A_STORE:   w = exit_word(16'h1704);
      A_OUTPUT:  w = exit_word(16'h3820);
      A_IDXINC:  w = exit_word(16'h0820);
      A_INPUT:   w = exit_word(16'h2914);
      default:   w = mk_word(16'h0000, CS_ALWAYS, mk_tgt(TK_ABS, A_FETCH),
                             mk_tgt(TK_ABS, A_FETCH));
    endcase
    return w;
  endfunction

  function automatic map_ent_t mk_ent(input logic [IDXW-1:0] v, input logic [IDXW-1:0] m,
                                      input logic [AW-1:0] d);
    map_ent_t e;
    e.val  = v;
    e.care = m;
    e.dest = d;
    return e;
  endfunction

  // dispatch table; the order of entries carries no priority
  function automatic map_ent_t map_rom(input int i);
    map_ent_t e;
    case (i)
      0:       e = mk_ent(9'h000, 9'h1FF, A_IDLE);
      1:       e = mk_ent(9'h000, 9'h1F0, A_LOADN);
      2:       e = mk_ent(9'h010, 9'h1F0, A_INCR);
      3:       e = mk_ent(9'h020, 9'h1F0, A_DECR);
      4:       e = mk_ent(9'h030, 9'h1F0, A_SHORTBR);
      5:       e = mk_ent(9'h040, 9'h1F0, A_LOADADV);
      6:       e = mk_ent(9'h050, 9'h1F0, A_STORE);
      7:       e = mk_ent(9'h060, 9'h1F8, A_OUTPUT);
      8:       e = mk_ent(9'h060, 9'h1FF, A_IDXINC);
      9:       e = mk_ent(9'h068, 9'h1F8, A_INPUT);
      default: e = mk_ent(9'h000, 9'h000, A_TRAP);
    endcase
    return e;
  endfunction

endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/useq_opmap.sv
module useq_opmap
  import useq_pkg::*;
#(
  parameter int N_ENT = N_MAP
) (
  input  logic [IDXW-1:0] idx,
  output logic [AW-1:0]   dest
);
  localparam int CNTW = $clog2(IDXW + 1);

  logic [N_ENT-1:0]  match;
  logic [CNTW-1:0]   spec  [N_ENT];
  logic [AW-1:0]     edest [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    localparam map_ent_t ENT = map_rom(g);
    assign match[g] = ((idx ^ ENT.val) & ENT.care) == '0;
    assign spec[g]  = CNTW'($countones(ENT.care));
    assign edest[g] = ENT.dest;
  end

  // most specific matching entry wins; equal specificity keeps the lower entry
  always_comb begin
    logic [CNTW-1:0] best;
    logic            found;
    dest  = A_TRAP;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (match[i] && (!found || spec[i] > best)) begin
        dest  = edest[i];
        best  = spec[i];
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/useq_nextsel.sv
module useq_nextsel
  import useq_pkg::*;
(
  input  logic [AW-1:0] upc,
  input  cond_sel_e     cond,
  input  target_t       tgt_a,
  input  target_t       tgt_b,
  input  logic [AW-1:0] map_dest,
  input  logic          cond_cont,
  input  logic          cond_branch,
  input  logic          cond_pend,
  output logic [AW-1:0] next_addr
);
  logic    take_a;
  target_t chosen;

  always_comb begin
    case (cond)
      CS_ALWAYS: take_a = 1'b1;
      CS_CONT:   take_a = cond_cont;
      CS_BRANCH: take_a = cond_branch;
      CS_PEND:   take_a = cond_pend;
      default:   take_a = 1'b1;
    endcase
    chosen = take_a ? tgt_a : tgt_b;
    case (chosen.kind)
      TK_ABS:  next_addr = chosen.addr;
      TK_NEXT: next_addr = upc + AW'(1);
      TK_MAP:  next_addr = map_dest;
      default: next_addr = A_FETCH;
    endcase
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_page,
  input  logic [7:0]    opcode,
  input  logic          cond_cont,
  input  logic          cond_branch,
  input  logic          cond_pend,
  output logic [4:0]    upc_addr,
  output logic [15:0]   ctrl_word
);
  logic          rst_int_n;
  logic [AW-1:0] upc_q;
  logic [AW-1:0] upc_d;
  logic [AW-1:0] map_dest;
  uword_t        uword;

  useq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  useq_opmap #(.N_ENT(N_MAP)) u_map (
    .idx  ({op_page, opcode}),
    .dest (map_dest)
  );

  always_comb begin
    uword = ucode_rom(upc_q);
  end

  useq_nextsel u_next (
    .upc         (upc_q),
    .cond        (uword.cond),
    .tgt_a       (uword.tgt_a),
    .tgt_b       (uword.tgt_b),
    .map_dest    (map_dest),
    .cond_cont   (cond_cont),
    .cond_branch (cond_branch),
    .cond_pend   (cond_pend),
    .next_addr   (upc_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) upc_q <= A_FETCH;
    else            upc_q <= upc_d;
  end

  assign upc_addr  = upc_q;
  assign ctrl_word = uword.ctrl;

  // dispatch loads the table result only from the fetch word
  assert_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upc_q == A_FETCH) |=> (upc_q == $past(map_dest)));

  assert_override_zero_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upc_q == A_FETCH && !op_page && opcode == 8'h00) |=> (upc_q == A_IDLE));

  assert_override_sixty_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upc_q == A_FETCH && !op_page && opcode == 8'h60) |=> (upc_q == A_IDXINC));

  assert_unmapped_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upc_q == A_FETCH && op_page) |=> (upc_q == A_TRAP));

  assert_exit_cont_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upc_q == A_INCR) |=> (upc_q == ($past(cond_cont) ? A_FETCH : A_SERVICE)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upc_q == A_IDLE && !cond_pend) |=> (upc_q == A_IDLE));

  assert_idle_leave_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upc_q == A_IDLE && cond_pend) |=> (upc_q == A_SERVICE));

  assert_branch_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upc_q == A_SHORTBR) |=> (upc_q == ($past(cond_branch) ? A_TAKEBR : A_SKIP)));

  assert_goto_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upc_q == A_LOADADV) |=> (upc_q == A_INCR));

  assert_service_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upc_q == A_SERVICE) |=> (upc_q == A_FETCH));
endmodule

// File: tb/useq_core_tb.sv
`timescale 1ns/1ps
module useq_core_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_page;
  logic [7:0] opcode;
  logic       cond_cont;
  logic       cond_branch;
  logic       cond_pend;
  logic [4:0] upc_addr;
  logic [15:0] ctrl_word;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  useq_core u_dut (
    .clk(clk), .rst_n(rst_n), .op_page(op_page), .opcode(opcode),
    .cond_cont(cond_cont), .cond_branch(cond_branch), .cond_pend(cond_pend),
    .upc_addr(upc_addr), .ctrl_word(ctrl_word)
  );

  function automatic int exp_ctrl(input int a);
    case (a)
      0: return 'h8101;  1: return 'h4202;  2: return 'h2314;  3: return 'h0008;
      4: return 'h0420;  5: return 'h0440;  6: return 'h2580;  7: return 'h0520;
      8: return 'h0610;  9: return 'h2314; 10: return 'h1704; 11: return 'h3820;
      12: return 'h0820; 13: return 'h2914;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_map(input bit pg, input int op);
    int hi;
    hi = op >> 4;
    if (pg) return 14;
    if (op == 'h00) return 3;
    if (op == 'h60) return 12;
    case (hi)
      0: return 2;  1: return 4;  2: return 5;  3: return 6;
      4: return 9;  5: return 10;
      6: return (op & 8) ? 13 : 11;
      default: return 14;
    endcase
  endfunction

  function automatic string map_tag(input bit pg, input int op);
    if (pg || (op >> 4) >= 7) return "R6";
    if (op == 'h00 || op == 'h60) return "R5";
    return "R4";
  endfunction

  function automatic int exp_next(input int a, input bit pg, input int op,
                                  input bit c, input bit b, input bit p);
    case (a)
      0: return exp_map(pg, op);
      1: return 0;
      3: return p ? 1 : 3;
      6: return b ? 8 : 7;
      9: return 4;
      2, 4, 5, 7, 8, 10, 11, 12, 13: return c ? 0 : 1;
      default: return 0;
    endcase
  endfunction

  function automatic string next_tag(input int a, input bit pg, input int op);
    case (a)
      0: return map_tag(pg, op);
      3: return "R8";
      6: return "R9";
      1, 9: return "R10";
      2, 4, 5, 7, 8, 10, 11, 12, 13: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  int    exp_upc;
  string exp_tag;
  int    spin_budget;

  // called just after a falling edge: check, predict, drive, advance
  task automatic step(input bit pg, input int op, input bit c, input bit b, input bit p);
    chk(exp_tag, "upc_addr", int'(upc_addr), exp_upc);
    chk("R2", "ctrl_word", int'(ctrl_word), exp_ctrl(int'(upc_addr)));
    exp_tag = next_tag(exp_upc, pg, op);
    exp_upc = exp_next(exp_upc, pg, op, c, b, p);
    op_page = pg; opcode = op[7:0];
    cond_cont = c; cond_branch = b; cond_pend = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    int dir_ops[14] = '{'h000, 'h060, 'h00F, 'h001, 'h067, 'h068, 'h06F, 'h05A,
                        'h100, 'h07F, 'h0FF, 'h030, 'h040, 'h160};
    int dir_idx = 0;
    seed = $urandom(32'h5EED);
    rst_n = 1'b0; op_page = 1'b0; opcode = 8'h00;
    cond_cont = 1'b1; cond_branch = 1'b0; cond_pend = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "upc_addr in reset", int'(upc_addr), 0);
    chk("R1", "ctrl_word in reset", int'(ctrl_word), 'h8101);
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1", "upc_addr during release", int'(upc_addr), 0);
      chk("R1", "ctrl_word during release", int'(ctrl_word), 'h8101);
    end
    exp_upc = 0;
    exp_tag = "R1";
    spin_budget = 20;

    for (int n = 0; n < 3000; n++) begin
      bit pg; int op; bit c; bit b; bit p;
      if ($urandom % 10 < 7) op = (($urandom % 7) << 4) | ($urandom % 16);
      else                   op = $urandom % 256;
      pg = ($urandom % 10) == 0;
      c  = ($urandom % 4) != 0;
      b  = $urandom % 2;
      p  = ($urandom % 10) < 3;
      if (exp_upc == 0 && dir_idx < 14) begin
        pg = dir_ops[dir_idx][8];
        op = dir_ops[dir_idx] & 'hFF;
        dir_idx++;
      end
      if (exp_upc == 3 && spin_budget > 0) begin
        p = 1'b0;
        spin_budget--;
      end
      step(pg, op, c, b, p);
    end
    chk(exp_tag, "final upc_addr", int'(upc_addr), exp_upc);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run hung actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule